// File: doc/BRIEF.md
# Reference-Following Square-Wave Timer with Holdover

This block regenerates a slow external pulse train (nominally 100 Hz) as a square wave. The wave is derived from a free-running counter on the fast system clock (36 MHz by default). The counter wraps at a programmable reload value. The counter is captured on every rising and falling edge of the reference. From the two captures the block estimates where the reference pulse centre sits within the counter period. It then steers the reload value so that the pulse centre moves to mid-period. The output wave is produced by comparing the counter against two thresholds, so its edges depend only on the counter and show no response-time jitter.

The very first rising reference edge after reset loads the counter directly, so tracking starts from a near-zero error. The correction passes through a first-order low-pass filter and a per-update step limit, and the reload value can never leave a fixed window around nominal.

When rising edges stop arriving, the block raises a loss flag and freezes the reload value. The wave keeps running at the last learned period. When edges return, tracking resumes from where it stopped, without realigning the counter. A configuration input can also freeze the correction on demand.

Top module: `hpl_phase_lock`

## Requirements
- R1: While reset is high and in the first cycle after it, `wave_out`, `locked` and `sig_lost` are all 0.
- R2: The counter counts 0..reload and then returns to 0, so one wave period is reload+1 clocks. With P = reload+1, `wave_out` is 1 exactly when the counter lies in [P>>2, (P>>2)+(P>>1)). This output is registered from the next counter value.
- R3: The first rising reference edge after reset loads the counter with (P>>2)+1. That edge causes no correction. As a result, `wave_out` is 1 in the following cycle and stays high for P>>1 cycles of the counter run that follows.
- R4: A falling edge that follows a captured rising edge produces a measurement, using the counter values at the rise (r) and fall (f). The span is s = f−r, plus P if that is negative. The midpoint is m = r+(s>>1), minus P if m ≥ P. The error is e = m−(P>>1), which falls in [−P/2, P/2). A positive error means the reference is late.
- R5: On each measurement, while tracking is enabled, the filter state is updated as F ← F + ((e−F)>>>FILT_SHIFT). The reload then moves toward RELOAD_NOM+F, by at most STEP_MAX counts per measurement.
- R6: The reload value always stays within RELOAD_NOM ± MAX_DEV.
- R7: When LOSS_LIM = 1.5·(RELOAD_NOM+1) cycles pass with no rising edge, `sig_lost` rises, `locked` and the lock run are cleared, and any pending rise capture is dropped. While lost, the reload is frozen and the wave keeps its last period.
- R8: A rising edge clears `sig_lost` in the next cycle. It is captured as a normal rise, without realigning the counter, and correction resumes with the fall that follows it.
- R9: `locked` rises after LOCK_COUNT consecutive measurements with |e| < LOCK_TOL. A measurement outside tolerance clears both `locked` and the run.
- R10: While `track_en` is 0, measurements still update the lock run, but the filter state and the reload are frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference pulse train, synchronous to clk |
| track_en | input | 1 | 1 lets measurements steer the reload value |
| wave_out | output | 1 | Regenerated square wave |
| locked | output | 1 | Phase error has stayed inside tolerance |
| sig_lost | output | 1 | Reference rising edges have stopped |

## Verification
The bench targets the alignment edge. A design that captures that edge as a measurement, or loads the wrong counter value, reports a spurious error and either fails to lock or shifts the wave by a count. A reference period longer than nominal drives the correction into its step limit and reload window. A missing clamp lets the wave period run past RELOAD_NOM+MAX_DEV+1, which the period measurement in holdover exposes. The reference is then removed and restored: a design that keeps adjusting while lost, keeps `locked` set, or realigns the counter on return diverges from the bench model cycle by cycle. A phase with tracking disabled shows whether the reload truly stays frozen.

// File: rtl/hpl_pkg.sv
package hpl_pkg;

    typedef enum logic {
        ACQ_SEEK,
        ACQ_RUN
    } acq_e;

    typedef struct packed {
        logic               fire;
        logic signed [31:0] err;
    } meas_t;

    function automatic int clampi(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    // wave high for counts in [P/4, P/4 + P/2)
    function automatic logic in_window(int c, int r);
        int p;
        int lo;
        p  = r + 1;
        lo = p >>> 2;
        return (c >= lo) && (c < lo + (p >>> 1));
    endfunction

endpackage

// File: rtl/hpl_edge_watch.sv
module hpl_edge_watch #(
    parameter int LOSS_LIM = 540000
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic rise,
    output logic fall,
    output logic lost,
    output logic lost_evt
);
    localparam int MW = $clog2(LOSS_LIM + 1);

    logic          ref_q;
    logic [MW-1:0] miss_q;
    logic          lost_q;

    assign rise     = ref_in & ~ref_q;
    assign fall     = ~ref_in & ref_q;
    assign lost_evt = ~rise & (miss_q == MW'(LOSS_LIM)) & ~lost_q;
    assign lost     = lost_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= 1'b0;
            miss_q <= '0;
            lost_q <= 1'b0;
        end else begin
            ref_q <= ref_in;
            if (rise) begin
                miss_q <= '0;
                lost_q <= 1'b0;
            end else if (miss_q == MW'(LOSS_LIM)) begin
                lost_q <= 1'b1;
            end else begin
                miss_q <= miss_q + MW'(1);
            end
        end
    end
endmodule

// File: rtl/hpl_phase_est.sv
module hpl_phase_est
    import hpl_pkg::*;
#(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic          fall,
    input  logic          lost_evt,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] reload,
    output logic          align,
    output logic [CW-1:0] align_val,
    output meas_t         meas
);
    acq_e          st_q;
    logic          have_q;
    logic [CW-1:0] rcap_q;

    int p_i, span_i, mid_i;

    always_comb begin
        p_i    = int'(reload) + 1;
        span_i = int'(cnt) - int'(rcap_q);
        if (span_i < 0) span_i = span_i + p_i;
        mid_i = int'(rcap_q) + (span_i >>> 1);
        if (mid_i >= p_i) mid_i = mid_i - p_i;
        meas.fire = fall & have_q;
        meas.err  = mid_i - (p_i >>> 1);
        align     = rise & (st_q == ACQ_SEEK);
        align_val = CW'((p_i >>> 2) + 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ACQ_SEEK;
            have_q <= 1'b0;
            rcap_q <= '0;
        end else begin
            if (align) begin
                st_q <= ACQ_RUN;
            end else if (rise) begin
                have_q <= 1'b1;
                rcap_q <= cnt;
            end else if (meas.fire || lost_evt) begin
                have_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hpl_period_ctl.sv
module hpl_period_ctl
    import hpl_pkg::*;
#(
    parameter int CW         = 20,
    parameter int RELOAD_NOM = 359999,
    parameter int MAX_DEV    = 360,
    parameter int STEP_MAX   = 8,
    parameter int FILT_SHIFT = 4,
    parameter int LOCK_TOL   = 64,
    parameter int LOCK_COUNT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  meas_t         meas,
    input  logic          track_en,
    input  logic          lost_evt,
    output logic [CW-1:0] reload_q,
    output logic [CW-1:0] reload_nxt,
    output logic          locked
);
    localparam int LW = $clog2(LOCK_COUNT + 1);

    logic signed [31:0] filt_q;
    logic signed [31:0] filt_nxt;
    logic [LW-1:0]      good_q;
    logic               lock_q;
    int                 step_i, rel_i;

    always_comb begin
        filt_nxt = filt_q;
        step_i   = 0;
        rel_i    = int'(reload_q);
        if (meas.fire && track_en) begin
            filt_nxt = filt_q + ((meas.err - filt_q) >>> FILT_SHIFT);
            step_i   = clampi(RELOAD_NOM + int'(filt_nxt) - int'(reload_q),
                              -STEP_MAX, STEP_MAX);
            rel_i    = clampi(int'(reload_q) + step_i,
                              RELOAD_NOM - MAX_DEV, RELOAD_NOM + MAX_DEV);
        end
        reload_nxt = CW'(rel_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= CW'(RELOAD_NOM);
            filt_q   <= '0;
            good_q   <= '0;
            lock_q   <= 1'b0;
        end else begin
            reload_q <= reload_nxt;
            filt_q   <= filt_nxt;
            if (lost_evt) begin
                good_q <= '0;
                lock_q <= 1'b0;
            end else if (meas.fire) begin
                if (iabs(int'(meas.err)) < LOCK_TOL) begin
                    if (good_q != LW'(LOCK_COUNT)) good_q <= good_q + LW'(1);
                    if (good_q >= LW'(LOCK_COUNT - 1)) lock_q <= 1'b1;
                end else begin
                    good_q <= '0;
                    lock_q <= 1'b0;
                end
            end
        end
    end

    assign locked = lock_q;
endmodule

// File: rtl/hpl_counter.sv
module hpl_counter
    import hpl_pkg::*;
#(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          align,
    input  logic [CW-1:0] align_val,
    input  logic [CW-1:0] reload,
    input  logic [CW-1:0] reload_nxt,
    output logic [CW-1:0] cnt,
    output logic          wave
);
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        if (align)             cnt_nxt = align_val;
        else if (cnt >= reload) cnt_nxt = '0;
        else                   cnt_nxt = cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            wave <= 1'b0;
        end else begin
            cnt  <= cnt_nxt;
            wave <= in_window(int'(cnt_nxt), int'(reload_nxt));
        end
    end
endmodule

// File: rtl/hpl_phase_lock.sv
module hpl_phase_lock
    import hpl_pkg::*;
#(
    parameter int RELOAD_NOM = 359999,
    parameter int MAX_DEV    = (RELOAD_NOM + 1) / 1000,
    parameter int STEP_MAX   = 8,
    parameter int FILT_SHIFT = 4,
    parameter int LOCK_TOL   = 64,
    parameter int LOCK_COUNT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic track_en,
    output logic wave_out,
    output logic locked,
    output logic sig_lost
);
    localparam int CW       = $clog2(RELOAD_NOM + MAX_DEV + 2);
    localparam int LOSS_LIM = ((RELOAD_NOM + 1) * 3) / 2;

    logic          rise, fall, lost, lost_evt, align;
    logic [CW-1:0] cnt, reload_q, reload_nxt, align_val;
    meas_t         meas;

    hpl_edge_watch #(.LOSS_LIM(LOSS_LIM)) u_edge (
        .clk(clk), .rst(rst), .ref_in(ref_in),
        .rise(rise), .fall(fall), .lost(lost), .lost_evt(lost_evt)
    );

    hpl_phase_est #(.CW(CW)) u_est (
        .clk(clk), .rst(rst), .rise(rise), .fall(fall), .lost_evt(lost_evt),
        .cnt(cnt), .reload(reload_q), .align(align), .align_val(align_val),
        .meas(meas)
    );

    hpl_period_ctl #(
        .CW(CW), .RELOAD_NOM(RELOAD_NOM), .MAX_DEV(MAX_DEV),
        .STEP_MAX(STEP_MAX), .FILT_SHIFT(FILT_SHIFT),
        .LOCK_TOL(LOCK_TOL), .LOCK_COUNT(LOCK_COUNT)
    ) u_ctl (
        .clk(clk), .rst(rst), .meas(meas), .track_en(track_en),
        .lost_evt(lost_evt), .reload_q(reload_q), .reload_nxt(reload_nxt),
        .locked(locked)
    );

    hpl_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .align(align), .align_val(align_val),
        .reload(reload_q), .reload_nxt(reload_nxt), .cnt(cnt), .wave(wave_out)
    );

    assign sig_lost = lost;
endmodule

// File: rtl/hpl_checks.sv
module hpl_checks #(
    parameter int CW         = 20,
    parameter int RELOAD_NOM = 359999,
    parameter int MAX_DEV    = 360,
    parameter int STEP_MAX   = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          track_en,
    input logic          lost,
    input logic          locked,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] reload_q
);
    // R6: reload window
    a_r6_reload_window: assert property (@(posedge clk) disable iff (rst)
        (int'(reload_q) >= RELOAD_NOM - MAX_DEV) &&
        (int'(reload_q) <= RELOAD_NOM + MAX_DEV));

    // R5: step limit per update
    a_r5_slew_limit: assert property (@(posedge clk) disable iff (rst)
        ((int'(reload_q) - int'($past(reload_q))) <= STEP_MAX) &&
        ((int'(reload_q) - int'($past(reload_q))) >= -STEP_MAX));

    // R7: holdover freezes the period
    a_r7_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        lost |=> $stable(reload_q));

    // R10: tracking disabled freezes the period
    a_r10_track_off: assert property (@(posedge clk) disable iff (rst)
        !track_en |=> $stable(reload_q));

    // R9 / R7: no lock while the reference is missing
    a_r9_no_lock_when_lost: assert property (@(posedge clk) disable iff (rst)
        lost |-> !locked);

    // R2: counter never exceeds the largest legal reload
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= RELOAD_NOM + MAX_DEV);
endmodule

bind hpl_phase_lock hpl_checks #(
    .CW(CW), .RELOAD_NOM(RELOAD_NOM), .MAX_DEV(MAX_DEV), .STEP_MAX(STEP_MAX)
) u_checks (
    .clk(clk), .rst(rst), .track_en(track_en), .lost(lost),
    .locked(locked), .cnt(cnt), .reload_q(reload_q)
);

// File: tb/tb_hpl_phase_lock.sv
`timescale 1ns/1ps
module tb_hpl_phase_lock;
    localparam int NOM   = 399;
    localparam int DEV   = 40;
    localparam int STEP  = 8;
    localparam int SH    = 4;
    localparam int TOL   = 64;
    localparam int LOCKN = 4;
    localparam int LOSS  = ((NOM + 1) * 3) / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic track_en = 1'b1;
    logic wave_out, locked, sig_lost;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    hpl_phase_lock #(
        .RELOAD_NOM(NOM), .MAX_DEV(DEV), .STEP_MAX(STEP),
        .FILT_SHIFT(SH), .LOCK_TOL(TOL), .LOCK_COUNT(LOCKN)
    ) dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .track_en(track_en),
        .wave_out(wave_out), .locked(locked), .sig_lost(sig_lost)
    );

    // ---------------- behavioural reference model ----------------
    int  m_cnt, m_rel, m_miss, m_rcap, m_filt, m_good;
    bit  m_wave, m_refq, m_lost, m_seek, m_have, m_lock;

    function automatic int clip(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_rel = NOM; m_miss = 0; m_rcap = 0; m_filt = 0;
            m_good = 0; m_wave = 0; m_refq = 0; m_lost = 0; m_seek = 1;
            m_have = 0; m_lock = 0;
        end else begin
            bit rise, fall, lev, aln, ev;
            int p, e, s, mid, nr, nc, lo;
            p    = m_rel + 1;
            rise = ref_in && !m_refq;
            fall = !ref_in && m_refq;
            lev  = !rise && (m_miss == LOSS) && !m_lost;
            aln  = rise && m_seek;
            ev   = fall && m_have;
            e = 0;
            if (ev) begin
                s = m_cnt - m_rcap;
                if (s < 0) s += p;
                mid = m_rcap + (s >>> 1);
                if (mid >= p) mid -= p;
                e = mid - (p >>> 1);
            end
            nr = m_rel;
            if (ev && track_en) begin
                m_filt = m_filt + ((e - m_filt) >>> SH);
                nr = clip(m_rel + clip(NOM + m_filt - m_rel, -STEP, STEP), NOM - DEV, NOM + DEV);
            end
            if (aln) nc = (p >>> 2) + 1;
            else if (m_cnt >= m_rel) nc = 0;
            else nc = m_cnt + 1;
            lo = (nr + 1) >>> 2;
            m_wave = (nc >= lo) && (nc < lo + ((nr + 1) >>> 1));
            if (lev) begin m_good = 0; m_lock = 0; end
            else if (ev) begin
                if ((e < 0 ? -e : e) < TOL) begin
                    if (m_good < LOCKN) m_good++;
                    if (m_good >= LOCKN) m_lock = 1;
                end else begin m_good = 0; m_lock = 0; end
            end
            if (aln) m_seek = 0;
            else if (rise) begin m_have = 1; m_rcap = m_cnt; end
            else if (ev || lev) m_have = 0;
            if (rise) begin m_miss = 0; m_lost = 0; end
            else if (m_miss == LOSS) m_lost = 1;
            else m_miss++;
            m_refq = ref_in;
            m_cnt = nc;
            m_rel = nr;
        end
    end

    // ---------------- checking ----------------
    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(tag, "wave_out", int'(wave_out), int'(m_wave));
            check("R9", "locked", int'(locked), int'(m_lock));
            check("R7", "sig_lost", int'(sig_lost), int'(m_lost));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=200000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive_ref(int per, int hi, int n);
        for (int k = 0; k < n; k++) begin
            ref_in = 1'b1;
            repeat (hi) @(negedge clk);
            ref_in = 1'b0;
            repeat (per - hi) @(negedge clk);
        end
    endtask

    task automatic wave_period(output int per);
        int t;
        while (!(wave_out == 1'b1)) @(negedge clk);
        while (wave_out == 1'b1) @(negedge clk);
        while (wave_out == 1'b0) @(negedge clk);
        t = 0;
        while (wave_out == 1'b1) begin @(negedge clk); t++; end
        while (wave_out == 1'b0) begin @(negedge clk); t++; end
        per = t;
    endtask

    initial begin
        int hc, p1, p2;
        repeat (6) @(negedge clk);
        check("R1", "wave_out in reset", int'(wave_out), 0);
        check("R1", "locked in reset", int'(locked), 0);
        check("R1", "sig_lost in reset", int'(sig_lost), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "wave_out after reset", int'(wave_out), 0);
        repeat (37) @(negedge clk);

        // R3 / R2: alignment edge and wave shape
        tag = "R2 R3";
        ref_in = 1'b1;
        hc = 0;
        for (int i = 1; i <= NOM + 1; i++) begin
            @(negedge clk);
            if (i == 1) check("R3", "wave high after align", int'(wave_out), 1);
            hc += int'(wave_out);
            if (i == (NOM + 1) / 2) ref_in = 1'b0;
        end
        check("R2", "wave high cycles per period", hc, (NOM + 1) / 2);

        // R9: lock on an ideal reference
        tag = "R9";
        drive_ref(NOM + 1, (NOM + 1) / 2, 6);
        check("R9", "locked on ideal reference", int'(locked), 1);

        // R4 / R5: slightly slow reference
        tag = "R4 R5";
        drive_ref(NOM + 5, (NOM + 5) / 2, 20);
        drive_ref(NOM - 3, (NOM - 3) / 2, 15);

        // R10: tracking disabled
        tag = "R10";
        track_en = 1'b0;
        drive_ref(NOM - 6, (NOM - 6) / 2, 2);
        p1 = m_rel + 1;
        fork
            drive_ref(NOM - 6, (NOM - 6) / 2, 8);
            begin wave_period(p2); check("R10", "period frozen", p2, p1); end
        join
        track_en = 1'b1;

        // R6: reference far slower than the window allows
        tag = "R6";
        drive_ref(NOM + 80, (NOM + 80) / 2, 40);

        // R7: holdover
        tag = "R7";
        p1 = m_rel + 1;
        repeat (LOSS + 400) @(negedge clk);
        check("R7", "sig_lost after gap", int'(sig_lost), 1);
        check("R7", "locked cleared by loss", int'(locked), 0);
        wave_period(p2);
        check("R7", "holdover period", p2, p1);
        check("R6", "period within window", int'(p2 <= NOM + DEV + 1), 1);

        // R8: reacquire
        tag = "R8";
        ref_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8", "sig_lost cleared by rise", int'(sig_lost), 0);
        repeat ((NOM + 1) / 2 - 2) @(negedge clk);
        ref_in = 1'b0;
        repeat ((NOM + 1) / 2) @(negedge clk);
        drive_ref(NOM + 1, (NOM + 1) / 2, 30);
        check("R8", "still present after return", int'(sig_lost), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule